// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects interrupt events at two levels and reduces them to one active-high interrupt pin. The inner level holds six sticky status bits, one per host-side event, each qualified by an enable bit. The OR of the qualified bits is gated by a master enable. The gated result is one of the event sources of the outer level, which has its own sticky status and enable pair. The outer level's masked OR reaches the pin through a level-sensitive hold stage. While a pin-enable configuration bit is 1 the stage passes the OR straight through. While the bit is 0 the stage keeps the last value it passed.

Software reaches all state through a small word-addressed port. The port has a write strobe and a combinational read-data output. Status bits are cleared by writing 1s to them. To switch the pin off cleanly, software clears every outer status bit while pin-enable is still 1, and only then writes pin-enable to 0. The pin is then frozen low.

Register map (word addresses): 0 inner status, 1 inner enable (bits 5:0 event enables, bit 31 master enable), 2 outer status, 3 outer enable, 4 configuration (bit 0 pin enable). Outer bit 0 is the inner summary. Outer bits 5:1 take the external outer events 4:0.

Top module: `irq_cascade_top`

## Requirements
- R1: After synchronous reset, every status bit, every enable bit, the master enable and pin enable read 0, and irq_pin is 0.
- R2: A 1 on inner_evt[i] at a clock edge sets inner status bit i (address 0) at that edge. The bit then stays 1 after the event goes away.
- R3: Writing address 0 or 2 clears exactly those status bits whose write-data bit is 1. Writing 0 bits changes nothing. If an event arrives at the same edge as a clear of its bit, the bit stays set.
- R4: When the master enable (address 1 bit 31) is 1 and any inner status bit with its enable set is 1, outer status bit 0 becomes 1 at the next clock edge.
- R5: While the master enable is 0, outer status bit 0 never becomes set, whatever the inner status and enables.
- R6: A clear of outer status bit 0 has no effect while the inner request is active. Once the inner request has dropped, the clear takes effect.
- R7: A 1 on outer_evt[k] at a clock edge sets outer status bit k+1 at that edge. That bit is sticky and cleared by writing 1.
- R8: While pin enable (address 4 bit 0) is 1, irq_pin equals the OR of (outer status AND outer enable), in the same cycle.
- R9: While pin enable is 0, irq_pin keeps the value it had when pin enable was last 1, whatever the outer status does.
- R10: If all outer status bits are cleared while pin enable is 1 and pin enable is then written to 0, irq_pin stays 0 even when new inner or outer events set status bits.
- R11: Unmapped addresses 5 to 7 read 0. Enable registers read back only their implemented bits, and unimplemented bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inner_evt | input | 6 | Inner-level event inputs |
| outer_evt | input | 5 | External outer-level events (outer status bits 5:1) |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pin | output | 1 | Active-high interrupt output |

## Verification
The bench builds the block with its defaults: six inner events, six outer sources, and the inner summary at outer bit 0. With these values the master-enable bit (31) is far apart from the event enables, so any leak between them shows up. The summary slot at position 0 sits right next to the external outer bits, so a misrouted source is visible in the status read-back. The stimulus covers event-versus-clear collisions, a clear of the summary bit while the inner request is active, and the pin hold state both while the pin is high and after the safe shutdown sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int MIE_BIT   = 31;
    localparam int PINEN_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_ISTAT = 3'd0,
        RA_IEN   = 3'd1,
        RA_OSTAT = 3'd2,
        RA_OEN   = 3'd3,
        RA_CFG   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic istat_clr;
        logic ien_we;
        logic ostat_clr;
        logic oen_we;
        logic cfg_we;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (a)
                RA_ISTAT: s.istat_clr = 1'b1;
                RA_IEN:   s.ien_we    = 1'b1;
                RA_OSTAT: s.ostat_clr = 1'b1;
                RA_OEN:   s.oen_we    = 1'b1;
                RA_CFG:   s.cfg_we    = 1'b1;
                default:  s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_level.sv
module irq_level #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] en_o,
    output logic         any_o
);

    logic [N-1:0] stat_q;
    logic [N-1:0] en_q;
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | set_i;
            if (en_we) en_q <= wbits;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign any_o  = |(stat_q & en_q);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            $past(set_i[i]) |-> stat_q[i]);  // R3
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            ($past(stat_q[i]) && !$past(clr_mask[i])) |-> stat_q[i]);  // R2
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int IN_N  = 6,
    parameter int OUT_N = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mie_wbit,
    input  logic              pinen_wbit,
    input  logic [IN_N-1:0]   istat,
    input  logic [IN_N-1:0]   ien,
    input  logic [OUT_N-1:0]  ostat,
    input  logic [OUT_N-1:0]  oen,
    output wr_strobe_t        strobe_o,
    output logic              mie_o,
    output logic              pinen_o,
    output logic [DATA_W-1:0] rdata
);

    logic mie_q;
    logic pinen_q;

    assign strobe_o = decode_write(wr_en, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mie_q   <= 1'b0;
            pinen_q <= 1'b0;
        end else begin
            if (strobe_o.ien_we) mie_q   <= mie_wbit;
            if (strobe_o.cfg_we) pinen_q <= pinen_wbit;
        end
    end

    assign mie_o   = mie_q;
    assign pinen_o = pinen_q;

    always_comb begin
        rdata = '0;
        case (addr)
            RA_ISTAT: rdata[IN_N-1:0] = istat;
            RA_IEN: begin
                rdata[IN_N-1:0] = ien;
                rdata[MIE_BIT]  = mie_q;
            end
            RA_OSTAT: rdata[OUT_N-1:0] = ostat;
            RA_OEN:   rdata[OUT_N-1:0] = oen;
            RA_CFG:   rdata[PINEN_BIT] = pinen_q;
            default:  rdata = '0;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));  // R11

endmodule

// File: rtl/irq_pin_hold.sv
module irq_pin_hold (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic d_i,
    output logic pin_o
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= 1'b0;
        else if (open_i) hold_q <= d_i;
    end

    assign pin_o = open_i ? d_i : hold_q;

    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!open_i && $past(!open_i)) |-> $stable(pin_o));  // R9

endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
    import irq_pkg::*;
#(
    parameter int IN_N    = 6,
    parameter int OUT_N   = 6,
    parameter int SUM_POS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_N-1:0]   inner_evt,
    input  logic [OUT_N-2:0]  outer_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_pin
);

    localparam int EXT_N = OUT_N - 1;

    wr_strobe_t       strobe;
    logic             mie;
    logic             pinen;
    logic [IN_N-1:0]  istat, ien;
    logic [OUT_N-1:0] ostat, oen;
    logic [OUT_N-1:0] oset;
    logic             inner_any;
    logic             inner_req;
    logic             outer_any;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;

    irq_level #(.N(IN_N)) u_inner (
        .clk    (clk),
        .rst    (rst),
        .set_i  (inner_evt),
        .clr_we (strobe.istat_clr),
        .en_we  (strobe.ien_we),
        .wbits  (wdata[IN_N-1:0]),
        .stat_o (istat),
        .en_o   (ien),
        .any_o  (inner_any)
    );

    assign inner_req = inner_any & mie;

    always_comb begin
        int k;
        k = 0;
        oset = '0;
        for (int j = 0; j < OUT_N; j++) begin
            if (j == SUM_POS) begin
                oset[j] = inner_req;
            end else begin
                oset[j] = outer_evt[k];
                k = k + 1;
            end
        end
    end

    irq_level #(.N(OUT_N)) u_outer (
        .clk    (clk),
        .rst    (rst),
        .set_i  (oset),
        .clr_we (strobe.ostat_clr),
        .en_we  (strobe.oen_we),
        .wbits  (wdata[OUT_N-1:0]),
        .stat_o (ostat),
        .en_o   (oen),
        .any_o  (outer_any)
    );

    irq_regs #(.IN_N(IN_N), .OUT_N(OUT_N)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (reg_addr),
        .mie_wbit   (wdata[MIE_BIT]),
        .pinen_wbit (wdata[PINEN_BIT]),
        .istat      (istat),
        .ien        (ien),
        .ostat      (ostat),
        .oen        (oen),
        .strobe_o   (strobe),
        .mie_o      (mie),
        .pinen_o    (pinen),
        .rdata      (rdata)
    );

    irq_pin_hold u_pin (
        .clk    (clk),
        .rst    (rst),
        .open_i (pinen),
        .d_i    (outer_any),
        .pin_o  (irq_pin)
    );

    AST_SUM_SET: assert property (@(posedge clk) disable iff (rst)
        $past(inner_req) |-> ostat[SUM_POS]);  // R4
    AST_MIE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!$past(mie) && !$past(ostat[SUM_POS])) |-> !ostat[SUM_POS]);  // R5
    AST_SUM_STAYS: assert property (@(posedge clk) disable iff (rst)
        ($past(ostat[SUM_POS]) && $past(inner_req && strobe.ostat_clr)) |-> ostat[SUM_POS]);  // R6
    AST_PIN_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        pinen |-> (irq_pin == |(ostat & oen)));  // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_pin && !pinen && !mie));  // R1

endmodule

// File: tb/sim_irq_cascade_top.sv
module sim_irq_cascade_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  inner_evt = '0;
    logic [4:0]  outer_evt = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    irq_cascade_top u0 (
        .clk       (clk),
        .rst       (rst),
        .inner_evt (inner_evt),
        .outer_evt (outer_evt),
        .wr_en     (wr_en),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_pin   (irq_pin)
    );

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_pin ? {31'b0, irq_pin} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_pin = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #5 -> chk_ev;
        #1;
    endtask

    task automatic pin_chk(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_pin = 1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        #5 -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse_in(input logic [5:0] m);
        @(negedge clk);
        inner_evt = m;
        @(negedge clk);
        inner_evt = '0;
    endtask

    task automatic pulse_out(input logic [4:0] m);
        @(negedge clk);
        outer_evt = m;
        @(negedge clk);
        outer_evt = '0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        pin_chk(1'b0, "R1 pin after reset");
        rd_chk(3'd0, 32'h0, "R1 inner status");
        rd_chk(3'd1, 32'h0, "R1 inner enable");
        rd_chk(3'd2, 32'h0, "R1 outer status");
        rd_chk(3'd3, 32'h0, "R1 outer enable");
        rd_chk(3'd4, 32'h0, "R1 config");

        // R2 sticky inner events
        pulse_in(6'b000101);
        rd_chk(3'd0, 32'h05, "R2 inner set");
        pulse_in(6'b100000);
        rd_chk(3'd0, 32'h25, "R2 inner accumulate");

        // R3 write-one-to-clear
        wr(3'd0, 32'h01);
        rd_chk(3'd0, 32'h24, "R3 clear bit0");
        wr(3'd0, 32'h00);
        rd_chk(3'd0, 32'h24, "R3 zero write");
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 3'd0; wdata = 32'h04; inner_evt = 6'b000100;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; inner_evt = '0;
        rd_chk(3'd0, 32'h24, "R3 event beats clear");

        // R5 master enable off blocks summary
        wr(3'd1, 32'h0000_003F);
        rd_chk(3'd1, 32'h3F, "R11 inner enable readback");
        rd_chk(3'd2, 32'h0, "R5 summary blocked");

        // R4 master on -> summary set
        wr(3'd1, 32'h8000_003F);
        rd_chk(3'd2, 32'h01, "R4 summary set");
        rd_chk(3'd1, 32'h8000_003F, "R11 master readback");
        pin_chk(1'b0, "R9 pin held low");

        // R6 summary clear blocked while inner active
        wr(3'd2, 32'h01);
        rd_chk(3'd2, 32'h01, "R6 clear ignored");
        wr(3'd0, 32'h3F);
        rd_chk(3'd0, 32'h0, "R3 inner cleared");
        wr(3'd2, 32'h01);
        rd_chk(3'd2, 32'h0, "R6 clear after drop");

        // R7 external outer events
        pulse_out(5'b00011);
        rd_chk(3'd2, 32'h06, "R7 outer ext set");
        pin_chk(1'b0, "R9 pin still low");

        // R8 transparent pin
        wr(3'd4, 32'h1);
        wr(3'd3, 32'h02);
        pin_chk(1'b1, "R8 pin high");
        rd_chk(3'd4, 32'h1, "R11 config readback");
        wr(3'd2, 32'h02);
        rd_chk(3'd2, 32'h04, "R7 outer clear");
        pin_chk(1'b0, "R8 pin low after clear");
        wr(3'd3, 32'h06);
        pin_chk(1'b1, "R8 pin high via bit2");

        // R9 hold while pin enable off
        wr(3'd4, 32'h0);
        pin_chk(1'b1, "R9 hold high");
        wr(3'd2, 32'h3F);
        rd_chk(3'd2, 32'h0, "R7 outer all cleared");
        pin_chk(1'b1, "R9 hold high after clear");
        wr(3'd4, 32'h1);
        pin_chk(1'b0, "R8 reopen low");

        // R10 safe shutdown sequence
        pulse_out(5'b00010);
        pin_chk(1'b1, "R8 pin high before shutdown");
        wr(3'd2, 32'h3F);
        pin_chk(1'b0, "R10 cleared low");
        wr(3'd4, 32'h0);
        pulse_out(5'b00010);
        rd_chk(3'd2, 32'h04, "R10 status still records");
        pin_chk(1'b0, "R10 pin frozen low outer");
        pulse_in(6'b000001);
        rd_chk(3'd2, 32'h05, "R10 summary recorded");
        pin_chk(1'b0, "R10 pin frozen low inner");

        // R11 unmapped and masked enables
        rd_chk(3'd5, 32'h0, "R11 addr5");
        rd_chk(3'd6, 32'h0, "R11 addr6");
        rd_chk(3'd7, 32'h0, "R11 addr7");
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk(3'd3, 32'h3F, "R11 outer enable masked");

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule